// File: doc/BRIEF.md
# Station Address Checksum Checker

This block verifies a 48-bit Ethernet station address as it is read out of an address PROM, one byte per strobe. The six address bytes are followed by two bytes that hold a 16-bit check value. The block pairs the address bytes into three 16-bit words, taking the first byte of each pair as the low half. It folds each word into a running sum. Before each word is added, the sum is doubled. The doubled value and the new total are each brought back into range by an end-around subtraction of 0xFFFF.

When the last check byte arrives, the block compares the folded sum with the stored value and raises a one-cycle completion pulse with a pass or fail flag. The captured address and the folded sum stay visible on the outputs. A start pulse clears the block for the next read. Reading the PROM and finding the signature that comes before the address are left to the surrounding logic.

Top module: `stn_addr_cksum`

## Requirements
- R1: After reset, and in the cycle after a start pulse, `done` and `good` are 0, `mac_out` is 0 and `sum_out` is 0. The next strobe is taken as byte 0.
- R2: Each of the first six accepted bytes is shifted into `mac_out` from the low end. The first byte therefore ends in bits 47:40 and the sixth byte in bits 7:0.
- R3: Bytes 1, 3 and 5 each complete a word {this byte, previous byte}. Before the word is added, the running sum is doubled, and if the doubled value exceeds 0xFFFF then 0xFFFF is subtracted from it.
- R4: After the word is added, if the sum exceeds 0xFFFF then 0xFFFF is subtracted from it. The sum is visible on `sum_out` from the cycle after the strobe.
- R5: When the running sum equals 0xFFFF, `sum_out` shows 0 instead, and the comparison uses 0.
- R6: Bytes 6 and 7 form the stored check value, with byte 6 as the low half. `good` is 1 when that value equals `sum_out` and 0 otherwise. `good` holds its value until the next start or reset.
- R7: `done` is high for exactly one cycle: the cycle after the eighth accepted strobe. `good` is valid in that same cycle.
- R8: Strobes after the eighth byte are ignored until a start pulse. `mac_out`, `sum_out`, `good` and `done` do not change.
- R9: A strobe in the same cycle as `start` is discarded. The following strobe is taken as byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears all state for a new address |
| byte_vld | input | 1 | Strobe: `byte_in` holds the next PROM byte |
| byte_in | input | 8 | PROM byte |
| done | output | 1 | One-cycle pulse when the check value has been compared |
| good | output | 1 | Stored check value matched the computed sum |
| mac_out | output | 48 | Captured address, first byte most significant |
| sum_out | output | 16 | Folded running sum, with 0xFFFF shown as 0 |

## Verification
On every cycle, the assertions check four things: the running sum never leaves the 16-bit range after reduction (R4), `sum_out` never shows 0xFFFF (R5), `done` lasts one cycle and comes only after the eighth strobe (R7), and the state after a start is clear while strobes past the eighth leave the outputs unchanged (R1, R8). Only the bench's scenarios can show that the arithmetic is right. They compare the outputs each cycle against a reference model that computes the sum with integers, and they cover a matching check value, a mismatching one, an address that folds to exactly 0xFFFF, and a strobe that collides with start.

// File: rtl/stn_addr_cksum.sv
module stn_addr_cksum #(
  parameter int SUM_W = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic        done,
  output logic        good,
  output logic [47:0] mac_out,
  output logic [15:0] sum_out
);
  localparam int NBYTES = 8;
  localparam int ABYTES = 6;
  localparam int CW     = $clog2(NBYTES + 1);
  localparam logic [SUM_W-1:0] MAXV = {{(SUM_W-16){1'b0}}, 16'hFFFF};

  logic [CW-1:0]    cnt_q;
  logic [SUM_W-1:0] sum_q;
  logic [7:0]       lo_q;
  logic [47:0]      mac_q;
  logic             done_q, good_q;

  wire take     = byte_vld && !start && (cnt_q < CW'(NBYTES));
  wire in_addr  = cnt_q < CW'(ABYTES);
  wire last     = cnt_q == CW'(NBYTES - 1);
  wire [15:0] word = {byte_in, lo_q};

  wire [SUM_W-1:0] dbl  = {sum_q[SUM_W-2:0], 1'b0};
  wire [SUM_W-1:0] red1 = (dbl > MAXV) ? dbl - MAXV : dbl;
  wire [SUM_W-1:0] add  = red1 + {{(SUM_W-16){1'b0}}, word};
  wire [SUM_W-1:0] red2 = (add > MAXV) ? add - MAXV : add;
  wire [15:0]      fin  = (sum_q[15:0] == 16'hFFFF) ? 16'h0000 : sum_q[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      lo_q   <= '0;
      mac_q  <= '0;
      done_q <= 1'b0;
      good_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= '0;
      sum_q  <= '0;
      lo_q   <= '0;
      mac_q  <= '0;
      done_q <= 1'b0;
      good_q <= 1'b0;
    end else begin
      done_q <= take && last;
      if (take) begin
        cnt_q <= cnt_q + 1'b1;
        if (!cnt_q[0]) lo_q <= byte_in;
        if (in_addr) mac_q <= {mac_q[39:0], byte_in};
        if (in_addr && cnt_q[0]) sum_q <= red2;
        if (last) good_q <= (word == fin);
      end
    end
  end

  assign done    = done_q;
  assign good    = good_q;
  assign mac_out = mac_q;
  assign sum_out = fin;

  a_r4_sum_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= MAXV);

  a_r5_no_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    sum_out != 16'hFFFF);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(byte_vld && !start && cnt_q == CW'(NBYTES - 1)));

  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0 && mac_out == '0 && sum_out == '0 && !done && !good));

  a_r8_extra_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(NBYTES) && !start) |=> ($stable(mac_out) && $stable(sum_out) && $stable(good) && !done));
endmodule

// File: tb/stn_addr_cksum_tb.sv
module stn_addr_cksum_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        done, good;
  logic [47:0] mac_out;
  logic [15:0] sum_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  stn_addr_cksum u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_vld(byte_vld),
    .byte_in(byte_in), .done(done), .good(good), .mac_out(mac_out), .sum_out(sum_out)
  );

  int          m_cnt, m_sum, m_lo;
  logic [47:0] m_mac;
  logic        m_done, m_good;

  function automatic int fold(int s);
    return (s == 65535) ? 0 : s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_sum = 0; m_lo = 0; m_mac = '0; m_done = 0; m_good = 0;
    end else if (start) begin
      m_cnt = 0; m_sum = 0; m_lo = 0; m_mac = '0; m_done = 0; m_good = 0;
    end else begin
      m_done = 0;
      if (byte_vld && m_cnt < 8) begin
        if (m_cnt < 6) m_mac = {m_mac[39:0], byte_in};
        if (m_cnt % 2 == 0) m_lo = byte_in;
        else if (m_cnt < 6) begin
          int s;
          s = m_sum * 2;
          if (s > 65535) s -= 65535;
          s += int'(byte_in) * 256 + m_lo;
          if (s > 65535) s -= 65535;
          m_sum = s;
        end
        if (m_cnt == 7) begin
          m_good = (fold(m_sum) == int'(byte_in) * 256 + m_lo);
          m_done = 1;
        end
        m_cnt++;
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 mac_out", mac_out, m_mac);
      chk("R3/R4/R5 sum_out", sum_out, fold(m_sum));
      chk("R7 done", done, m_done);
      chk("R6 good", good, m_good);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int ref_ck(logic [7:0] b[6]);
    int s = 0;
    for (int k = 0; k < 3; k++) begin
      s = s << 1;
      if (s > 65535) s -= 65535;
      s += int'(b[2*k]) + int'(b[2*k+1]) * 256;
      if (s > 65535) s -= 65535;
    end
    return fold(s);
  endfunction

  task automatic put(logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_in  = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(logic [7:0] b[6], int ck);
    pulse_start();
    for (int k = 0; k < 6; k++) put(b[k]);
    put(ck[7:0]);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_in  = ck[15:8];
    @(negedge clk);
    byte_vld = 1'b0;
    chk("R7 done pulse", done, 1);
    chk("R6 good vs ref", good, ref_ck(b) == ck);
    chk("R2 mac order", mac_out, {b[0], b[1], b[2], b[3], b[4], b[5]});
    @(negedge clk);
    chk("R7 done falls", done, 0);
  endtask

  initial begin
    logic [7:0] a[6];
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset mac", mac_out, 0);
    chk("R1 reset sum", sum_out, 0);
    rst_n = 1'b1;

    a = '{8'h08, 8'h00, 8'h2B, 8'h12, 8'h34, 8'h56};
    run(a, ref_ck(a));
    chk("R6 match good", good, 1);
    run(a, ref_ck(a) ^ 16'h0100);
    chk("R6 mismatch bad", good, 0);

    a = '{8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00};
    run(a, 0);
    chk("R5 all-ones folds to zero", sum_out, 0);
    chk("R5 good with zero check", good, 1);

    a = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFE};
    run(a, ref_ck(a));
    chk("R3 R4 reduction case good", good, 1);

    for (int n = 0; n < 6; n++) begin
      for (int k = 0; k < 6; k++) a[k] = 8'($urandom);
      run(a, (n % 2 == 0) ? ref_ck(a) : int'(16'($urandom)));
    end

    put(8'hAA);
    put(8'h55);
    chk("R8 extra bytes ignored mac", mac_out, {a[0], a[1], a[2], a[3], a[4], a[5]});
    chk("R8 extra bytes no done", done, 0);

    @(negedge clk);
    start = 1'b1; byte_vld = 1'b1; byte_in = 8'h99;
    @(negedge clk);
    start = 1'b0; byte_vld = 1'b0;
    chk("R1 start clears mac", mac_out, 0);
    chk("R1 start clears good", good, 0);
    put(8'h11);
    chk("R9 collided byte dropped", mac_out, 48'h11);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule